// File: doc/BRIEF.md
# Aperture-Based Address Remapper

This block sits on the address path of one bus master and turns each 32-bit master address into a slave select code and a translated address. The master's 4 GB space is cut into 16 windows of 256 MB, selected by the top four address bits. Every window carries a 4-bit slave code and a 4-bit target window number. The translated address keeps the low 28 bits of the master address and replaces the top nibble with the target window number. Many master windows may therefore land on one target window, and a window may be moved to a different number.

Software programs the map through a small 32-bit register port. The four map words hold one nibble per window and are staged in shadow storage. A separate update register copies the whole shadow map into the active map in a single cycle, so a half-written map never steers traffic. Translation is combinational from the active map. A window whose active slave code is 0 is unmapped, and a lookup that hits it raises a decode-error flag.

Top module: `aperture_remap`

## Requirements
- R1: After reset both maps are all zeros. A valid lookup to any window gives lk_err=1 and lk_slave=0, and every map register reads 0.
- R2: The window index is lk_addr[31:28]. Window i occupies nibble bits [4i+3:4i] of its word. Slave codes for windows 0-7 are at offset 0x00, for windows 8-15 at 0x04. Target numbers for windows 0-7 are at 0x08, for windows 8-15 at 0x0C.
- R3: lk_taddr is always {target window number, lk_addr[27:0]}, using the active map. This holds on a decode error as well.
- R4: Writes to the map registers leave the translation in use unchanged until a write to the update register at offset 0x10 with bit 0 set.
- R5: A commit takes effect from the cycle after the update write. A lookup in the same cycle as the update write still uses the old map.
- R6: A valid lookup to a window whose active slave code is 0 drives lk_err=1 and lk_slave=0. Any other valid lookup drives lk_err=0 and lk_slave equal to the active code.
- R7: The map registers read back their shadow contents. The update register reads 0. Any other offset reads 0, and a write to it changes nothing.
- R8: While lk_valid is 0, lk_slave is 0 and lk_err is 0.
- R9: Several master windows may share one slave and one target number. A window may also map to a differently numbered target window.
- R10: A write to the update register with bit 0 clear does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| lk_valid | input | 1 | Lookup address valid |
| lk_addr | input | 32 | Master address to translate |
| lk_slave | output | 4 | Slave select code, 0 when unmapped or idle |
| lk_taddr | output | 32 | Translated address |
| lk_err | output | 1 | Decode error for the current lookup |

## Verification
The hardest case to reach is the commit boundary. The update write must coincide with a lookup, so that the sample taken just before the clock edge shows the old map and the sample one cycle later shows the new one. The bench drives the update write and the lookup together in one half cycle and samples on both sides of the edge. It also stages a changed map whose effect is visible only after commit, so that a shadow leaking into the active map shows up as a wrong slave code.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_IDX_W  = 4;
  localparam int unsigned DEF_REG_W  = 32;
  localparam int unsigned DEF_REG_AW = 5;

  // result of one lookup
  typedef struct packed {
    logic [DEF_IDX_W-1:0] slave;
    logic                 err;
  } lk_res_t;
endpackage

// File: rtl/remap_rst_sync.sv
module remap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/remap_regfile.sv
module remap_regfile #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NUM_AP = 16,
  parameter int unsigned FLD_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [REG_AW-1:0]       addr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output logic [NUM_AP*FLD_W-1:0] sel_shd,
  output logic [NUM_AP*FLD_W-1:0] off_shd,
  output logic [NUM_AP*FLD_W-1:0] sel_act,
  output logic [NUM_AP*FLD_W-1:0] off_act,
  output logic                    commit
);
  localparam int unsigned MAP_W = NUM_AP * FLD_W;
  localparam int unsigned WPF   = MAP_W / REG_W;
  localparam int unsigned BYTES = REG_W / 8;
  localparam logic [REG_AW-1:0] UPD_OFF = REG_AW'(2 * WPF * BYTES);

  logic [MAP_W-1:0] sel_shd_q, sel_shd_d;
  logic [MAP_W-1:0] off_shd_q, off_shd_d;
  logic [MAP_W-1:0] sel_act_q, off_act_q;
  logic             shd_en;

  // shadow next state: one word per matching offset
  always_comb begin
    sel_shd_d = sel_shd_q;
    off_shd_d = off_shd_q;
    shd_en    = 1'b0;
    for (int w = 0; w < WPF; w++) begin
      if (we && addr == REG_AW'(w * BYTES)) begin
        sel_shd_d[w*REG_W +: REG_W] = wdata;
        shd_en = 1'b1;
      end
      if (we && addr == REG_AW'((WPF + w) * BYTES)) begin
        off_shd_d[w*REG_W +: REG_W] = wdata;
        shd_en = 1'b1;
      end
    end
  end

  assign commit = we && (addr == UPD_OFF) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_shd_q <= '0;
      off_shd_q <= '0;
    end else if (shd_en) begin
      sel_shd_q <= sel_shd_d;
      off_shd_q <= off_shd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_act_q <= '0;
      off_act_q <= '0;
    end else if (commit) begin
      sel_act_q <= sel_shd_q;
      off_act_q <= off_shd_q;
    end
  end

  // read mux over shadow words; update and holes read 0
  always_comb begin
    rdata = '0;
    for (int w = 0; w < WPF; w++) begin
      if (addr == REG_AW'(w * BYTES))         rdata = sel_shd_q[w*REG_W +: REG_W];
      if (addr == REG_AW'((WPF + w) * BYTES)) rdata = off_shd_q[w*REG_W +: REG_W];
    end
  end

  assign sel_shd = sel_shd_q;
  assign off_shd = off_shd_q;
  assign sel_act = sel_act_q;
  assign off_act = off_act_q;
endmodule

// File: rtl/remap_decode.sv
module remap_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                             valid,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [(1<<IDX_W)*IDX_W-1:0]      sel_map,
  input  logic [(1<<IDX_W)*IDX_W-1:0]      off_map,
  output logic [IDX_W-1:0]                 slave,
  output logic [ADDR_W-1:0]                taddr,
  output logic                             err
);
  localparam int unsigned LOW_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] code;
  logic [IDX_W-1:0] tgt;

  assign idx  = addr[ADDR_W-1 -: IDX_W];
  assign code = sel_map[idx*IDX_W +: IDX_W];
  assign tgt  = off_map[idx*IDX_W +: IDX_W];

  always_comb begin
    taddr = {tgt, addr[LOW_W-1:0]};
    err   = valid && (code == '0);
    slave = valid ? code : '0;
  end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned REG_AW = DEF_REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [IDX_W-1:0]  lk_slave,
  output logic [ADDR_W-1:0] lk_taddr,
  output logic              lk_err
);
  localparam int unsigned NUM_AP = 1 << IDX_W;
  localparam int unsigned MAP_W  = NUM_AP * IDX_W;

  logic             rst_sync_n;
  logic [MAP_W-1:0] sel_shd, off_shd, sel_act, off_act;
  logic             commit;

  remap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  remap_regfile #(
    .REG_W (REG_W),
    .REG_AW(REG_AW),
    .NUM_AP(NUM_AP),
    .FLD_W (IDX_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .sel_shd(sel_shd),
    .off_shd(off_shd),
    .sel_act(sel_act),
    .off_act(off_act),
    .commit (commit)
  );

  remap_decode #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_dec (
    .valid  (lk_valid),
    .addr   (lk_addr),
    .sel_map(sel_act),
    .off_map(off_act),
    .slave  (lk_slave),
    .taddr  (lk_taddr),
    .err    (lk_err)
  );
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned REG_AW = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [REG_AW-1:0]           cfg_addr,
  input logic [REG_W-1:0]            cfg_rdata,
  input logic                        lk_valid,
  input logic [ADDR_W-1:0]           lk_addr,
  input logic [IDX_W-1:0]            lk_slave,
  input logic [ADDR_W-1:0]           lk_taddr,
  input logic                        lk_err,
  input logic                        commit,
  input logic [(1<<IDX_W)*IDX_W-1:0] sel_shd,
  input logic [(1<<IDX_W)*IDX_W-1:0] off_shd,
  input logic [(1<<IDX_W)*IDX_W-1:0] sel_act,
  input logic [(1<<IDX_W)*IDX_W-1:0] off_act
);
  localparam int unsigned LOW_W = ADDR_W - IDX_W;
  localparam int unsigned WPF   = ((1 << IDX_W) * IDX_W) / REG_W;
  localparam logic [REG_AW-1:0] UPD_OFF = REG_AW'(2 * WPF * (REG_W / 8));

  // R6
  err_zero_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_err |-> lk_slave == '0);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_err && lk_slave == '0));

  // R3
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> lk_taddr[LOW_W-1:0] == lk_addr[LOW_W-1:0]);

  // R4
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(sel_act) && $stable(off_act)));

  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (sel_act == $past(sel_shd) && off_act == $past(off_shd)));

  // R7
  upd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == UPD_OFF |-> cfg_rdata == '0);
endmodule

bind aperture_remap remap_chk #(
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W),
  .REG_W (REG_W),
  .REG_AW(REG_AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cfg_addr (cfg_addr),
  .cfg_rdata(cfg_rdata),
  .lk_valid (lk_valid),
  .lk_addr  (lk_addr),
  .lk_slave (lk_slave),
  .lk_taddr (lk_taddr),
  .lk_err   (lk_err),
  .commit   (commit),
  .sel_shd  (sel_shd),
  .off_shd  (off_shd),
  .sel_act  (sel_act),
  .off_act  (off_act)
);

// File: tb/aperture_remap_bench.sv
`timescale 1ns/1ps
module aperture_remap_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic [3:0]  lk_slave;
  logic [31:0] lk_taddr;
  logic        lk_err;

  int n_chk;
  int n_bad;
  bit done;

  aperture_remap u_aperture_remap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_slave(lk_slave), .lk_taddr(lk_taddr), .lk_err(lk_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {addr, slave, taddr, err}
  localparam int NV = 12;
  localparam logic [68:0] VEC [NV] = '{
    {32'h8000_1234, 4'd1, 32'h0000_1234, 1'b0},
    {32'h9ABC_DEF0, 4'd1, 32'h1ABC_DEF0, 1'b0},
    {32'hB000_0004, 4'd1, 32'h3000_0004, 1'b0},
    {32'h0FFF_FFFF, 4'd3, 32'h0FFF_FFFF, 1'b0},
    {32'h1000_0000, 4'd3, 32'h1000_0000, 1'b0},
    {32'h2345_6789, 4'd2, 32'h0345_6789, 1'b0},
    {32'h5555_5555, 4'd0, 32'h0555_5555, 1'b1},
    {32'hC000_0000, 4'd0, 32'h0000_0000, 1'b1},
    {32'hD123_4567, 4'd3, 32'hD123_4567, 1'b0},
    {32'hEFFF_FFFF, 4'd3, 32'hEFFF_FFFF, 1'b0},
    {32'hF000_0010, 4'd6, 32'h0000_0010, 1'b0},
    {32'h7FFF_FFFF, 4'd0, 32'h0FFF_FFFF, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 5'h1f; cfg_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #5 chk(tag, cfg_rdata, exp);
  endtask

  task automatic look(input string tag, input logic [31:0] a,
                      input logic [3:0] es, input logic [31:0] ea, input logic ee);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    #5;
    chk({tag, " slave"}, {28'd0, lk_slave}, {28'd0, es});
    chk({tag, " taddr"}, lk_taddr, ea);
    chk({tag, " err"},   {31'd0, lk_err}, {31'd0, ee});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 5'h1f; cfg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    look("R1 reset lookup", 32'h8000_0000, 4'd0, 32'h0000_0000, 1'b1);
    look("R1 reset lookup hi", 32'hF123_4567, 4'd0, 32'h0123_4567, 1'b1);
    rd("R1 reset sel lo", 5'h00, 32'h0);
    rd("R1 reset off hi", 5'h0C, 32'h0);

    // R8 idle
    @(negedge clk); lk_valid = 1'b0; lk_addr = 32'h8000_0000;
    #5 chk("R8 idle slave", {28'd0, lk_slave}, 32'd0);
    chk("R8 idle err", {31'd0, lk_err}, 32'd0);

    // R2 program shadow words
    wr(5'h00, 32'h0000_0233);
    wr(5'h04, 32'h6330_1111);
    wr(5'h08, 32'h0000_0010);
    wr(5'h0C, 32'h0ED0_3210);
    rd("R2 R7 sel lo readback", 5'h00, 32'h0000_0233);
    rd("R2 R7 sel hi readback", 5'h04, 32'h6330_1111);
    rd("R2 R7 off lo readback", 5'h08, 32'h0000_0010);
    rd("R2 R7 off hi readback", 5'h0C, 32'h0ED0_3210);
    rd("R7 update reads zero", 5'h10, 32'h0);

    // R4 not committed yet
    look("R4 before commit", 32'h8000_1234, 4'd0, 32'h0000_1234, 1'b1);

    // R10 update with bit 0 clear
    wr(5'h10, 32'hFFFF_FFFE);
    look("R10 no commit", 32'h8000_1234, 4'd0, 32'h0000_1234, 1'b1);

    // R5 commit with lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'h10; cfg_wdata = 32'h1;
    lk_valid = 1'b1; lk_addr = 32'h8000_1234;
    #5 chk("R5 same cycle old map err", {31'd0, lk_err}, 32'd1);
    chk("R5 same cycle old map slave", {28'd0, lk_slave}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 5'h1f; cfg_wdata = '0;
    #5 chk("R5 next cycle new map slave", {28'd0, lk_slave}, 32'd1);
    chk("R5 next cycle new map err", {31'd0, lk_err}, 32'd0);

    // R3 R6 R9 vector table
    for (int i = 0; i < NV; i++) begin
      look($sformatf("R3 R6 R9 vec%0d", i), VEC[i][68:37], VEC[i][36:33],
           VEC[i][32:1], VEC[i][0]);
    end

    // R7 undefined offset write ignored
    wr(5'h14, 32'hFFFF_FFFF);
    rd("R7 hole reads zero", 5'h14, 32'h0);
    rd("R7 hole write no effect", 5'h00, 32'h0000_0233);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd("R7 hole write no effect hi", 5'h0C, 32'h0ED0_3210);
    look("R7 map unchanged", 32'h2000_0000, 4'd2, 32'h0000_0000, 1'b0);

    // R4 restage window 8 and window 3, check old map until commit
    wr(5'h04, 32'h6330_1117);
    wr(5'h00, 32'h0000_5233);
    wr(5'h08, 32'h0000_9010);
    look("R4 staged win8 old", 32'h8000_0001, 4'd1, 32'h0000_0001, 1'b0);
    look("R4 staged win3 old", 32'h3000_0002, 4'd0, 32'h0000_0002, 1'b1);
    wr(5'h10, 32'h1);
    look("R4 committed win8", 32'h8000_0001, 4'd7, 32'h0000_0001, 1'b0);
    look("R4 R9 committed win3", 32'h3000_0002, 4'd5, 32'h9000_0002, 1'b0);

    @(negedge clk); lk_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule